// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between the execute stage of a 32-bit integer core and a little-endian data memory port that is one word wide. The effective address is formed from a base register value and a signed 12-bit offset. For a store, the unit issues a word-aligned address and a byte-enable mask, and puts the store data on the byte lanes that the mask selects. For a load, it issues the same kind of word-aligned request and remembers the size code, the low address bits and the destination register.

The memory returns its word one cycle after a load request. The unit then picks out the addressed byte, halfword or word, extends it with sign or zero bits according to the size code, and presents it as a register-file write. An access whose size code has no meaning, or whose address does not suit its size, raises a flag for the core's trap logic and sends no request to memory.

Top module: `lsu_lane_align`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits, wrapping modulo 2^32. `mem_addr` is that address with bits [1:0] forced to zero.
- R2: A byte access (funct3 000, or 100 for a load) enables only lane `ea[1:0]`, so `mem_be` = 4'b0001 shifted left by `ea[1:0]`. On a byte store, `mem_wdata` holds `req_wdata[7:0]` in all four lanes.
- R3: A halfword access (funct3 001, or 101 for a load) drives `mem_be` = 4'b0011 shifted left by 2*`ea[1]`. On a halfword store, `mem_wdata` holds `req_wdata[15:0]` in both halves.
- R4: A word access (funct3 010) drives `mem_be` = 4'b1111, and a word store passes `req_wdata` through unchanged.
- R5: A halfword with `ea[0]`=1, or a word with `ea[1:0]`≠0, raises `misaligned` in the same cycle. `mem_req` stays low and `mem_be` is 0.
- R6: A load with funct3 011, 110 or 111, or a store with funct3 above 010, raises `illegal` in the same cycle. `mem_req` stays low and `misaligned` stays low.
- R7: A legal, aligned request drives `mem_req`=1 in the same cycle, with `mem_we` equal to `req_is_store`. With `req_valid` low, `mem_req`, `misaligned` and `illegal` are all 0.
- R8: One cycle after an accepted load, `rf_we`=1 and `rf_waddr` equals the load's `req_rd`.
- R9: For a byte load, `rf_wdata` is bits [8*lo+7 : 8*lo] of `mem_rdata`, where lo is the request's `ea[1:0]`. Funct3 000 sign-extends it and funct3 100 zero-extends it.
- R10: For a halfword load, `rf_wdata` is the halfword at byte offset lo of `mem_rdata`, sign-extended for funct3 001 and zero-extended for 101. A word load returns `mem_rdata` unchanged.
- R11: A load whose `req_rd` is 0 still issues its memory request, but gives `rf_we`=0 in the following cycle.
- R12: A store, a misaligned load or an illegal load gives `rf_we`=0 in the following cycle, and after reset `rf_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_is_store | input | 1 | 1 for a store, 0 for a load |
| req_funct3 | input | 3 | Size and extension code |
| req_base | input | 32 | Base register value |
| req_offset | input | 12 | Signed address offset |
| req_wdata | input | 32 | Store data, taken from its low bits |
| req_rd | input | 5 | Load destination register index |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write select |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Load word, one cycle after the request |
| misaligned | output | 1 | Address does not suit the access size |
| illegal | output | 1 | Size code not valid for this access |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | 32 | Extended load result |

## Verification
On every cycle, the assertions check that a flagged access never reaches memory, that the two flags never rise together, that an issued request has the number of enabled lanes its size calls for, and that a register write follows exactly the loads that are accepted and have a nonzero destination. The values themselves can only be shown by the bench's sweeps: which lane is enabled, the replicated store data, and the extended load result for each offset and data pattern. The sweeps cover every funct3 code, both directions and all four address offsets, with positive and negative offsets.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
    localparam int unsigned XLEN  = 32;
    localparam int unsigned OFS_W = 12;
    localparam int unsigned RIX_W = 5;
    localparam int unsigned NLANE = XLEN / 8;
    localparam int unsigned LO_W  = $clog2(NLANE);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic             valid;
        logic [2:0]       f3;
        logic [LO_W-1:0]  lo;
        logic [RIX_W-1:0] rd;
    } load_pend_t;
endpackage

// File: rtl/lsu_size_decode.sv
module lsu_size_decode
    import lsu_align_pkg::*;
(
    input  logic              is_store,
    input  logic [2:0]        f3,
    input  logic [LO_W-1:0]   lo,
    output acc_size_e         size,
    output logic              bad_code,
    output logic              bad_align,
    output logic [NLANE-1:0]  lanes
);
    always_comb begin
        size = SZ_NONE;
        case (f3)
            3'b000:  size = SZ_BYTE;
            3'b001:  size = SZ_HALF;
            3'b010:  size = SZ_WORD;
            3'b100:  size = is_store ? SZ_NONE : SZ_BYTE;
            3'b101:  size = is_store ? SZ_NONE : SZ_HALF;
            default: size = SZ_NONE;
        endcase
        bad_code = (size == SZ_NONE);
        case (size)
            SZ_BYTE: begin
                lanes     = 4'b0001 << lo;
                bad_align = 1'b0;
            end
            SZ_HALF: begin
                lanes     = 4'b0011 << {lo[1], 1'b0};
                bad_align = lo[0];
            end
            SZ_WORD: begin
                lanes     = 4'b1111;
                bad_align = |lo;
            end
            default: begin
                lanes     = '0;
                bad_align = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
    import lsu_align_pkg::*;
(
    input  acc_size_e        size,
    input  logic [XLEN-1:0]  src,
    output logic [XLEN-1:0]  lane_data
);
    always_comb begin
        case (size)
            SZ_BYTE: lane_data = {NLANE{src[7:0]}};
            SZ_HALF: lane_data = {(NLANE/2){src[15:0]}};
            default: lane_data = src;
        endcase
    end
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend
    import lsu_align_pkg::*;
(
    input  logic [XLEN-1:0]  word,
    input  logic [2:0]       f3,
    input  logic [LO_W-1:0]  lo,
    output logic [XLEN-1:0]  result
);
    logic [XLEN-1:0] shifted;

    always_comb begin
        shifted = word >> {lo, 3'b000};
        case (f3[1:0])
            2'b00: result = {{(XLEN-8){~f3[2] & shifted[7]}}, shifted[7:0]};
            2'b01: result = {{(XLEN-16){~f3[2] & shifted[15]}}, shifted[15:0]};
            default: result = word;
        endcase
    end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lsu_align_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_is_store,
    input  logic [2:0]            req_funct3,
    input  logic [XLEN-1:0]       req_base,
    input  logic [OFS_W-1:0]      req_offset,
    input  logic [XLEN-1:0]       req_wdata,
    input  logic [RIX_W-1:0]      req_rd,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [XLEN-1:0]       mem_addr,
    output logic [NLANE-1:0]      mem_be,
    output logic [XLEN-1:0]       mem_wdata,
    input  logic [XLEN-1:0]       mem_rdata,
    output logic                  misaligned,
    output logic                  illegal,
    output logic                  rf_we,
    output logic [RIX_W-1:0]      rf_waddr,
    output logic [XLEN-1:0]       rf_wdata
);
    logic [XLEN-1:0]   eff_addr;
    acc_size_e         size;
    logic              bad_code;
    logic              bad_align;
    logic [NLANE-1:0]  lanes;
    logic              accept;
    load_pend_t        pend_d, pend_q;

    assign eff_addr = req_base + {{(XLEN-OFS_W){req_offset[OFS_W-1]}}, req_offset};

    lsu_size_decode u_dec (
        .is_store  (req_is_store),
        .f3        (req_funct3),
        .lo        (eff_addr[LO_W-1:0]),
        .size      (size),
        .bad_code  (bad_code),
        .bad_align (bad_align),
        .lanes     (lanes)
    );

    lsu_store_steer u_steer (
        .size      (size),
        .src       (req_wdata),
        .lane_data (mem_wdata)
    );

    lsu_load_extend u_ext (
        .word   (mem_rdata),
        .f3     (pend_q.f3),
        .lo     (pend_q.lo),
        .result (rf_wdata)
    );

    always_comb begin
        accept     = req_valid && !bad_code && !bad_align;
        mem_req    = accept;
        mem_we     = req_is_store;
        mem_addr   = {eff_addr[XLEN-1:LO_W], {LO_W{1'b0}}};
        mem_be     = accept ? lanes : '0;
        illegal    = req_valid && bad_code;
        misaligned = req_valid && !bad_code && bad_align;

        pend_d       = pend_q;
        pend_d.valid = accept && !req_is_store && (req_rd != '0);
        if (accept && !req_is_store) begin
            pend_d.f3 = req_funct3;
            pend_d.lo = eff_addr[LO_W-1:0];
            pend_d.rd = req_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign rf_we    = pend_q.valid;
    assign rf_waddr = pend_q.rd;

    // R5, R6: a flagged access must not reach memory
    assert_fault_blocks_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (misaligned || illegal) |-> (!mem_req && mem_be == '0));

    // R6: the two flags are mutually exclusive
    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(misaligned && illegal));

    // R2: byte requests enable exactly one lane
    assert_byte_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && req_funct3[1:0] == 2'b00) |-> ($countones(mem_be) == 1));

    // R3: halfword requests enable two lanes
    assert_half_two_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && req_funct3[1:0] == 2'b01) |-> ($countones(mem_be) == 2));

    // R8: an accepted load with a nonzero destination writes back next cycle
    assert_load_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && req_rd != '0) |=> (rf_we && rf_waddr == $past(req_rd)));

    // R11: no write to register zero
    assert_no_zero_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr != '0));

    // R12: no write-back after a store or a flagged request
    assert_no_spurious_wb_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req || mem_we) |=> !rf_we);
endmodule

// File: tb/lsu_lane_align_test.sv
module lsu_lane_align_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_store = 1'b0;
    logic [2:0]  req_funct3 = '0;
    logic [31:0] req_base = '0;
    logic [11:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic [4:0]  req_rd = '0;
    logic        mem_req, mem_we, misaligned, illegal, rf_we;
    logic [31:0] mem_addr, mem_wdata, rf_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;
    logic [4:0]  rf_waddr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lsu_lane_align uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
        .req_funct3(req_funct3), .req_base(req_base), .req_offset(req_offset),
        .req_wdata(req_wdata), .req_rd(req_rd), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .misaligned(misaligned), .illegal(illegal),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // size: 0 byte, 1 half, 2 word, 3 invalid
    function automatic int size_of(input bit st, input int f3);
        if (f3 == 0) return 0;
        if (f3 == 1) return 1;
        if (f3 == 2) return 2;
        if (!st && f3 == 4) return 0;
        if (!st && f3 == 5) return 1;
        return 3;
    endfunction

    function automatic logic [31:0] extend(input logic [31:0] w, input int f3, input int lo);
        logic [31:0] sh;
        logic [31:0] v;
        sh = w >> (8 * lo);
        if (f3 == 0 || f3 == 4) begin
            v = sh & 32'hFF;
            if (f3 == 0 && v[7]) v = v | 32'hFFFF_FF00;
        end else if (f3 == 1 || f3 == 5) begin
            v = sh & 32'hFFFF;
            if (f3 == 1 && v[15]) v = v | 32'hFFFF_0000;
        end else begin
            v = w;
        end
        return v;
    endfunction

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        if (!done) begin
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [3];
        pats[0] = 32'h8A7B_F1C2;
        pats[1] = 32'h7F80_017E;
        pats[2] = 32'hFFFF_0000;

        repeat (3) @(negedge clk);
        #1;
        chk(rf_we == 1'b0, "R12 reset rf_we", {31'd0, rf_we}, 32'd0);
        chk(mem_req == 1'b0 && !misaligned && !illegal, "R7 idle outputs",
            {29'd0, mem_req, misaligned, illegal}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int st = 0; st < 2; st++) begin
            for (int f3 = 0; f3 < 8; f3++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    for (int oi = 0; oi < 2; oi++) begin
                        for (int pi = 0; pi < 3; pi++) begin
                            int sz;
                            bit bad, mis, acc;
                            logic [31:0] ea, ebe, ewd, wd;
                            logic [4:0] rd;
                            sz  = size_of(st != 0, f3);
                            bad = (sz == 3);
                            mis = !bad && ((sz == 1 && lo[0]) || (sz == 2 && lo != 0));
                            acc = !bad && !mis;
                            rd  = (pi == 2) ? 5'd0 : 5'(1 + f3 + 8 * pi + lo);
                            wd  = pats[pi] ^ 32'h1357_9BDF;
                            @(negedge clk);
                            req_valid    = 1'b1;
                            req_is_store = st[0];
                            req_funct3   = 3'(f3);
                            if (oi == 0) begin
                                req_base   = 32'h0000_4000 + 32'(lo) + 32'(16 * pi);
                                req_offset = 12'h024;
                                ea = 32'h0000_4024 + 32'(lo) + 32'(16 * pi);
                            end else begin
                                req_base   = 32'hF000_1008 + 32'(lo);
                                req_offset = 12'hFF8; // -8
                                ea = 32'hF000_1000 + 32'(lo);
                            end
                            req_wdata = wd;
                            req_rd    = rd;
                            #1;
                            chk(illegal == bad, "R6 illegal flag", {31'd0, illegal}, {31'd0, bad});
                            chk(misaligned == mis, "R5 misaligned flag", {31'd0, misaligned}, {31'd0, mis});
                            chk(mem_req == acc, "R7 mem_req", {31'd0, mem_req}, {31'd0, acc});
                            if (sz == 0)      ebe = 32'(1) << lo;
                            else if (sz == 1) ebe = 32'(3) << (lo & 2);
                            else              ebe = 32'hF;
                            if (!acc) ebe = 0;
                            chk(mem_be == ebe[3:0],
                                sz == 0 ? "R2 byte lanes" : sz == 1 ? "R3 half lanes" : "R4 lanes/R5 suppress",
                                {28'd0, mem_be}, ebe);
                            if (acc) begin
                                chk(mem_addr == (ea & 32'hFFFF_FFFC), "R1 word address", mem_addr, ea & 32'hFFFF_FFFC);
                                chk(mem_we == st[0], "R7 mem_we", {31'd0, mem_we}, {31'd0, st[0]});
                                if (st != 0) begin
                                    if (sz == 0)      ewd = {4{wd[7:0]}};
                                    else if (sz == 1) ewd = {2{wd[15:0]}};
                                    else              ewd = wd;
                                    chk(mem_wdata == ewd,
                                        sz == 0 ? "R2 byte data" : sz == 1 ? "R3 half data" : "R4 word data",
                                        mem_wdata, ewd);
                                end
                            end
                            @(negedge clk);
                            req_valid = 1'b0;
                            mem_rdata = pats[pi];
                            #1;
                            if (acc && st == 0 && rd != 0) begin
                                chk(rf_we == 1'b1, "R8 rf_we", {31'd0, rf_we}, 32'd1);
                                chk(rf_waddr == rd, "R8 rf_waddr", {27'd0, rf_waddr}, {27'd0, rd});
                                chk(rf_wdata == extend(pats[pi], f3, lo),
                                    sz == 0 ? "R9 byte extend" : "R10 half/word extend",
                                    rf_wdata, extend(pats[pi], f3, lo));
                            end else begin
                                chk(rf_we == 1'b0, (acc && st == 0) ? "R11 rd zero" : "R12 no write",
                                    {31'd0, rf_we}, 32'd0);
                            end
                        end
                    end
                end
            end
        end

        @(negedge clk);
        #1;
        chk(!mem_req && !misaligned && !illegal, "R7 valid low",
            {29'd0, mem_req, misaligned, illegal}, 32'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule